// File: doc/BRIEF.md
# Line BIP-8 Parity Checker

This block watches the descrambled byte stream of an STS-1 frame and keeps an even, eight-lane interleaved parity over every byte except the section overhead. When a frame ends, its parity is kept. The parity byte that arrives in the next frame is compared against it. Each mismatch adds to a running error count. Depending on a mode input, the count grows by the number of disagreeing bits or by at most one per frame.

An external performance-monitor strobe copies the running count into an 18-bit holding register and restarts the count in the same cycle. When the count passes its maximum, a configuration input selects whether it stops at the top value or wraps around. A one-cycle pulse marks every frame whose parity check failed.

Bytes enter on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a byte is taken on every cycle in which `in_valid` is high. The upstream side may insert idle cycles anywhere. Each accepted byte carries three markers: frame start, section overhead, and parity byte. The block reads these markers only on accepted beats.

Top module: `bip8_line_checker`

## Requirements
- R1: The parity of a frame is the XOR of all its accepted non-overhead bytes, and that includes the parity byte carried in that frame. Bit i of the result is the even parity of bit i over those bytes.
- R2: Accepted bytes marked as section overhead (`in_soh`=1) have no effect on the parity.
- R3: The parity byte of a frame (the beat with `in_b2`=1) is compared with the parity of the previous complete frame. A frame is complete when it was opened by an `in_sof` beat and closed by the next one. No comparison is made and no error is counted until a complete frame exists.
- R4: With `blk_mode`=0, each compared frame adds the number of set bits in (received byte XOR computed byte) to the count, a value from 0 to 8.
- R5: With `blk_mode`=1, each compared frame adds 1 if any bit differs and 0 otherwise.
- R6: A cycle with `pm_strobe`=1 loads `hold_cnt` with the running count as it stood before that edge, and sets the running count to zero.
- R7: With `sat_mode`=1, an addition that would exceed 2^CNT_W-1 leaves the running count at 2^CNT_W-1.
- R8: With `sat_mode`=0, the running count wraps modulo 2^CNT_W.
- R9: An increment that reaches the counter in the same cycle as `pm_strobe` is neither lost nor copied into `hold_cnt`. It becomes the first value of the new count window.
- R10: `err_pulse` goes high for exactly the one cycle after an accepted parity beat whose comparison gave a nonzero increment. It is low in every other cycle. After reset, `err_pulse` and `hold_cnt` are 0.
- R11: `in_ready` is always 1. Beats with `in_valid`=0 change neither the parity, nor the framing, nor the count, whatever their data and markers carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream ready, constant 1 |
| in_data | input | 8 | Descrambled byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_soh | input | 1 | Beat is a section overhead byte |
| in_b2 | input | 1 | Beat is the line parity byte |
| blk_mode | input | 1 | 1 selects block counting, 0 selects bit counting |
| sat_mode | input | 1 | 1 saturates on overflow, 0 wraps |
| pm_strobe | input | 1 | Snapshot-and-clear strobe |
| hold_cnt | output | CNT_W (18) | Count captured by the last strobe |
| err_pulse | output | 1 | One-cycle pulse per failed frame check |

## Verification
The bench drives four kinds of parity byte:
- A correct byte shows that overhead bytes are left out and that the parity byte is part of its own frame.
- A byte with one flipped bit and a fully inverted byte separate bit counting from block counting.
- Random masks test the population count across all lanes.

Random overhead lengths and idle beats that carry junk markers test that only accepted, non-overhead beats take part. A deliberately wrong parity byte in the first frame after reset tests that the first frame is not compared. Long runs of fully inverted bytes push the count past the top in both overflow modes, using a narrowed counter. A strobe placed on the cycle where an increment lands tests which window receives that increment.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
  localparam int unsigned LANES = 8;
  localparam int unsigned INC_W = $clog2(LANES + 1);

  typedef logic [LANES-1:0] lane_t;
  typedef logic [INC_W-1:0] inc_t;

  // number of lanes whose parity disagrees
  function automatic inc_t lane_errs(lane_t d);
    inc_t n;
    n = '0;
    for (int i = 0; i < LANES; i++) n = n + inc_t'(d[i]);
    return n;
  endfunction
endpackage

// File: rtl/bip8_frame_accum.sv
module bip8_frame_accum
  import bip8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sof,
  input  logic  soh,
  input  lane_t data,
  output lane_t prev_par,
  output logic  prev_ok
);
  lane_t acc;
  logic  opened;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      opened   <= 1'b0;
      prev_par <= '0;
      prev_ok  <= 1'b0;
    end else if (beat) begin
      if (sof) begin
        acc    <= soh ? '0 : data;
        opened <= 1'b1;
        if (opened) begin
          prev_par <= acc;
          prev_ok  <= 1'b1;
        end
      end else if (!soh) begin
        acc <= acc ^ data;
      end
    end
  end
endmodule

// File: rtl/bip8_compare.sv
module bip8_compare
  import bip8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  b2,
  input  lane_t data,
  input  lane_t prev_par,
  input  logic  prev_ok,
  input  logic  blk_mode,
  output inc_t  inc_q,
  output logic  err_pulse
);
  lane_t diff;
  inc_t  inc_d;
  logic  take;

  always_comb begin
    diff  = data ^ prev_par;
    take  = beat && b2 && prev_ok;
    inc_d = blk_mode ? inc_t'(|diff) : lane_errs(diff);
    if (!take) inc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      inc_q     <= inc_d;
      err_pulse <= (inc_d != '0);
    end
  end
endmodule

// File: rtl/bip8_err_counter.sv
module bip8_err_counter
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  inc_t             inc,
  input  logic             sat_mode,
  input  logic             pm_strobe,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] hold_cnt
);
  localparam int unsigned PAD = CNT_W - INC_W;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] inc_ext;

  always_comb begin
    inc_ext = {{PAD{1'b0}}, inc};
    sum     = {1'b0, run_cnt} + {1'b0, inc_ext};
    if (sum[CNT_W] && sat_mode) nxt = '1;
    else                        nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else if (pm_strobe) begin
      hold_cnt <= run_cnt;
      run_cnt  <= inc_ext;
    end else begin
      run_cnt  <= nxt;
    end
  end
endmodule

// File: rtl/bip8_line_checker.sv
module bip8_line_checker
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_soh,
  input  logic             in_b2,
  input  logic             blk_mode,
  input  logic             sat_mode,
  input  logic             pm_strobe,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             err_pulse
);
  logic             beat;
  lane_t            prev_par;
  logic             prev_ok;
  inc_t             inc_q;
  logic [CNT_W-1:0] run_cnt;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;

  bip8_frame_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .sof      (in_sof),
    .soh      (in_soh),
    .data     (in_data),
    .prev_par (prev_par),
    .prev_ok  (prev_ok)
  );

  bip8_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .b2        (in_b2),
    .data      (in_data),
    .prev_par  (prev_par),
    .prev_ok   (prev_ok),
    .blk_mode  (blk_mode),
    .inc_q     (inc_q),
    .err_pulse (err_pulse)
  );

  bip8_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc_q),
    .sat_mode  (sat_mode),
    .pm_strobe (pm_strobe),
    .run_cnt   (run_cnt),
    .hold_cnt  (hold_cnt)
  );
endmodule

// File: rtl/bip8_line_checker_sva.sv
module bip8_line_checker_sva
  import bip8_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_b2,
  input logic             blk_mode,
  input logic             sat_mode,
  input logic             pm_strobe,
  input logic             err_pulse,
  input logic [CNT_W-1:0] hold_cnt,
  input logic [CNT_W-1:0] run_cnt,
  input inc_t             inc_q
);
  logic [1:0] sof_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_seen <= '0;
    else if (in_valid && in_sof && sof_seen != 2'd2) sof_seen <= sof_seen + 2'd1;
  end

  // R10: a pulse only follows an accepted parity beat
  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid && in_b2));

  // R3: no error before a complete frame exists
  assert_first_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (sof_seen == 2'd2));

  // R5: block mode adds exactly one per failed frame
  assert_block_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(blk_mode)) |-> (inc_q == inc_t'(1)));

  // R6: strobe snapshots the running count
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pm_strobe) |-> (hold_cnt == $past(run_cnt)));

  // R9: increment landing with the strobe opens the new window
  assert_coincident_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pm_strobe) |-> (run_cnt == CNT_W'($past(inc_q))));

  // R7: saturated count stays at the top
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode && !pm_strobe && (&run_cnt)) |=> (&run_cnt));
endmodule

bind bip8_line_checker bip8_line_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_b2     (in_b2),
  .blk_mode  (blk_mode),
  .sat_mode  (sat_mode),
  .pm_strobe (pm_strobe),
  .err_pulse (err_pulse),
  .hold_cnt  (hold_cnt),
  .run_cnt   (run_cnt),
  .inc_q     (inc_q)
);

// File: tb/bip8_line_checker_bench.sv
module bip8_line_checker_bench;
  localparam int unsigned TB_CNT_W = 10;
  localparam int MAXV = (1 << TB_CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [7:0]          in_data = '0;
  logic                in_sof = 1'b0;
  logic                in_soh = 1'b0;
  logic                in_b2 = 1'b0;
  logic                blk_mode = 1'b0;
  logic                sat_mode = 1'b1;
  logic                pm_strobe = 1'b0;
  logic [TB_CNT_W-1:0] hold_cnt;
  logic                err_pulse;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [7:0] m_acc = '0;
  logic [7:0] m_prev = '0;
  bit         m_have = 0;
  bit         m_open = 0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  bip8_line_checker #(.CNT_W(TB_CNT_W)) u_bip8_line_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_soh(in_soh), .in_b2(in_b2),
    .blk_mode(blk_mode), .sat_mode(sat_mode), .pm_strobe(pm_strobe),
    .hold_cnt(hold_cnt), .err_pulse(err_pulse)
  );

  function automatic int popc(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic int cnt_add(int c, int inc, bit sat);
    int s = c + inc;
    if (s > MAXV) s = sat ? MAXV : s - (MAXV + 1);
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one cycle at a negedge, returns the increment of a parity beat
  task automatic drive(bit v, bit sof, bit soh, bit b2, logic [7:0] d,
                       bit strb, string req, output int inc);
    int exp_p;
    inc = 0;
    in_valid = v; in_sof = sof; in_soh = soh; in_b2 = b2; in_data = d;
    pm_strobe = strb;
    if (v) begin
      if (b2 && m_have) inc = blk_mode ? ((d != m_prev) ? 1 : 0) : popc(d ^ m_prev);
      if (sof) begin
        if (m_open) begin m_prev = m_acc; m_have = 1; end
        m_acc = soh ? 8'h00 : d;
        m_open = 1;
      end else if (!soh) begin
        m_acc = m_acc ^ d;
      end
    end
    @(negedge clk);
    exp_p = (inc != 0) ? 1 : 0;
    check(err_pulse == exp_p[0], {req, " err_pulse"}, err_pulse, exp_p);
  endtask

  task automatic idle_junk();
    int dummy;
    drive(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 1'b0, "R11", dummy);
  endtask

  // kind: 0 correct, 1 random mask, 2 inverted, 3 single bit
  task automatic send_frame(int n_soh, int n_pay, int kind, bit co, string req);
    int inc, dummy, hold_exp;
    logic [7:0] mask;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'($urandom), 1'b0, req, dummy);
    for (int i = 1; i < n_soh; i++) begin
      if ($urandom % 4 == 0) idle_junk();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 8'($urandom), 1'b0, req, dummy);
    end
    case (kind)
      0: mask = 8'h00;
      1: mask = 8'($urandom);
      2: mask = 8'hFF;
      default: mask = 8'(1 << ($urandom % 8));
    endcase
    drive(1'b1, 1'b0, 1'b0, 1'b1, m_prev ^ mask, 1'b0, req, inc);
    hold_exp = m_cnt;
    if (co) m_cnt = inc;
    else    m_cnt = cnt_add(m_cnt, inc, sat_mode);
    for (int i = 0; i < n_pay; i++) begin
      if (!(co && i == 0) && $urandom % 4 == 0) idle_junk();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 8'($urandom), co && i == 0, req, dummy);
      if (co && i == 0) check(hold_cnt == TB_CNT_W'(hold_exp), "R9 hold", hold_cnt, hold_exp);
    end
    pm_strobe = 1'b0;
  endtask

  task automatic strobe(string req);
    int dummy, exp;
    exp = m_cnt;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, req, dummy);
    pm_strobe = 1'b0;
    check(hold_cnt == TB_CNT_W'(exp), {req, " hold_cnt"}, hold_cnt, exp);
    m_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hold_cnt == '0, "R10 reset hold_cnt", hold_cnt, 0);
    check(err_pulse == 1'b0, "R10 reset err_pulse", err_pulse, 0);
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // first frame: wrong parity byte, must not be counted
    blk_mode = 1'b0; sat_mode = 1'b1;
    send_frame(3, 4, 2, 1'b0, "R3");
    send_frame(3, 4, 0, 1'b0, "R3");
    strobe("R3");

    // random bit-mode traffic
    for (int f = 0; f < 40; f++)
      send_frame(1 + int'($urandom % 4), 1 + int'($urandom % 6), int'($urandom % 4), 1'b0, "R4");
    strobe("R4 R6");
    strobe("R6 cleared");

    // overhead exclusion, then full inversion
    send_frame(4, 3, 0, 1'b0, "R2");
    send_frame(4, 3, 2, 1'b0, "R1");
    strobe("R1");

    // block mode
    blk_mode = 1'b1;
    for (int f = 0; f < 30; f++)
      send_frame(1 + int'($urandom % 3), 1 + int'($urandom % 5), int'($urandom % 4), 1'b0, "R5");
    strobe("R5");

    // strobe coincides with the increment
    blk_mode = 1'b0;
    send_frame(2, 3, 2, 1'b1, "R9");
    strobe("R9 new window");

    // saturation
    sat_mode = 1'b1;
    for (int f = 0; f < 140; f++) send_frame(1, 1, 2, 1'b0, "R7");
    strobe("R7");

    // wrap
    sat_mode = 1'b0;
    for (int f = 0; f < 140; f++) send_frame(1, 1, 2, 1'b0, "R8");
    strobe("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule